// File: doc/BRIEF.md
# PCI Interrupt Pin Routing Table

This block is a small, byte-addressable register region that decides which of eight shared interrupt request lines (PIRQ A to H, index 0 to 7) each PCI slot's four interrupt pins (INTA to INTD) drive. Seven consecutive device numbers, 25 through 31, each own a 16-bit routing word. Each word holds one 4-bit field per pin. The field for pin n starts at bit 4*n, and its low three bits give the PIRQ index. Device 30 is the exception. Its word is hard-wired to read as zero and ignores writes. Its pins always land on PIRQ E to H in pin order. Every slot outside the programmable range follows a fixed rotating default, ((slot + pin) mod 4) + 4. That default keeps it on PIRQ E to H and away from A to D.

Software reaches the region through a simple strobe interface. An access carries a byte address and a length of 0 to 4 bytes. The address is first reduced to an offset inside the region. The length is then cut so the access never runs past the region's last byte. Data is copied byte by byte in little-endian order. Read data is registered and comes back one cycle later. Bytes past the shortened length read as zero. A combinational lookup port returns the PIRQ index for any (slot, pin) pair. A one-cycle pulse tells downstream logic that the routing may have changed.

Top module: `pci_pin_router`

## Requirements
- R1: After reset, the routing word of each programmable device reads bytes 0x10, 0x32, 0x00, 0x00, which is word 0x3210. Device k (25 to 31) sits at offset 8 + 4*(k-25). The device 30 word reads zero. The control word at offset 48 reads 0x00000021. Every other byte reads zero. The pulse output and the read-valid output are low.
- R2: Only the low 6 bits of the access address select the byte. Address A and address A + 64*m reach the same byte.
- R3: An access that starts at offset o with requested length n touches only min(n, 64 - o) bytes. A read returns zero in every byte lane at or above that count.
- R4: Data byte lane i goes to and comes from offset o + i, in little-endian order. A length above 4 acts as 4. A length of 0 touches no byte. Unwritten bytes keep their value.
- R5: The four bytes at offsets 28 to 31 (device 30) always read zero, and writes to them are dropped.
- R6: For slots 25 to 29 and 31, the lookup returns bits [4*pin+2 : 4*pin] of that device's routing word. The result reflects a write from the cycle after the write.
- R7: For slot 30, the lookup returns pin + 4, whatever was written.
- R8: For slots 0 to 24, the lookup returns ((slot + pin) mod 4) + 4.
- R9: The pulse output is high for exactly the one cycle after each write strobe. This includes writes to read-only bytes and zero-length writes. It stays low after reads and idle cycles.
- R10: The read-valid output is high the cycle after a read strobe, with the data of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe, one access per cycle |
| acc_rd | input | 1 | Read strobe |
| acc_addr | input | 16 | Byte address, reduced modulo the region size |
| acc_len | input | 3 | Access length in bytes |
| acc_wdata | input | 32 | Write data, lane 0 is the lowest address |
| acc_rdata | output | 32 | Registered read data |
| acc_rvalid | output | 1 | Read data valid |
| lk_slot | input | 5 | Lookup slot number |
| lk_pin | input | 2 | Lookup pin, 0 = INTA to 3 = INTD |
| lk_pirq | output | 3 | PIRQ index for the lookup pair |
| route_chg | output | 1 | One-cycle routing-changed pulse |

## Verification
Several properties are checked on every cycle:
- a clipped access always fits inside the region;
- storage holds still in any cycle that has no write;
- the read-valid and routing-changed pulses follow their strobes by exactly one cycle;
- short reads leave their upper lanes at zero;
- the lookup never leaves PIRQ E to H for default slots or for device 30.

Other behaviour can only be shown by the bench's scenarios against its own byte-level model:
- the exact reset image;
- address aliasing;
- dropped writes to device 30;
- clipping at the region's top edge;
- the field position each programmable slot decodes.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;

  typedef logic [2:0] pirq_t;

  // Rotating default route for slots without a routing word: lands on E..H.
  function automatic pirq_t slot_default_pirq(logic [4:0] slot, logic [1:0] pin);
    logic [1:0] rot;
    rot = slot[1:0] + pin;
    return {1'b1, rot};
  endfunction

  // PIRQ index held in the field of a routing word that belongs to one pin.
  function automatic pirq_t field_pirq(logic [15:0] word, logic [1:0] pin, int shift);
    return word[int'(pin)*shift +: 3];
  endfunction

  // True for the bytes of the hard-wired (read-only zero) routing word.
  function automatic bit is_fixed_byte(int b, int base, int fixed_k);
    return (b >= base + 4*fixed_k) && (b < base + 4*fixed_k + 4);
  endfunction

  // Reset image of one byte of the region.
  function automatic logic [7:0] reset_byte(int b, int base, int ndev, int fixed_k,
                                            logic [15:0] rdef, int cofs,
                                            logic [31:0] cdef);
    logic [7:0] v;
    v = '0;
    for (int k = 0; k < ndev; k++) begin
      if (k != fixed_k && b == base + 4*k)     v = rdef[7:0];
      if (k != fixed_k && b == base + 4*k + 1) v = rdef[15:8];
    end
    for (int i = 0; i < 4; i++) begin
      if (b == cofs + i) v = cdef[8*i +: 8];
    end
    return v;
  endfunction

endpackage

// File: rtl/pr_access_clip.sv
module pr_access_clip #(
  parameter int AW           = 16,
  parameter int REGION_BYTES = 64,
  localparam int OFS_W       = $clog2(REGION_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [AW-1:0]    addr,
  input  logic [2:0]       len,
  output logic [OFS_W-1:0] off,
  output logic [2:0]       clen
);

  logic [2:0]     req_len;
  logic [OFS_W:0] room;

  assign off     = addr[OFS_W-1:0];
  assign req_len = (len > 3'd4) ? 3'd4 : len;
  assign room    = (OFS_W+1)'(REGION_BYTES) - {1'b0, off};
  assign clen    = ({{(OFS_W-2){1'b0}}, req_len} > room) ? room[2:0] : req_len;

  // R3: a shortened access never reaches beyond the last byte
  p_fit_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> ({1'b0, off} + {{(OFS_W-2){1'b0}}, clen}) <= (OFS_W+1)'(REGION_BYTES));

endmodule

// File: rtl/pr_byte_store.sv
module pr_byte_store
  import pin_route_pkg::*;
#(
  parameter int          REGION_BYTES  = 64,
  parameter int          ROUTE_BASE    = 8,
  parameter int          NUM_DEV       = 7,
  parameter int          FIXED_K       = 5,
  parameter logic [15:0] ROUTE_DEFAULT = 16'h3210,
  parameter int          CTRL_OFS      = 48,
  parameter logic [31:0] CTRL_DEFAULT  = 32'h0000_0021,
  localparam int         OFS_W         = $clog2(REGION_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [OFS_W-1:0]          off,
  input  logic [2:0]                clen,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic                      rvalid,
  output logic [REGION_BYTES*8-1:0] bytes_flat
);

  for (genvar b = 0; b < REGION_BYTES; b++) begin : g_byte
    localparam bit         RO   = is_fixed_byte(b, ROUTE_BASE, FIXED_K);
    localparam logic [7:0] INIT = reset_byte(b, ROUTE_BASE, NUM_DEV, FIXED_K,
                                             ROUTE_DEFAULT, CTRL_OFS, CTRL_DEFAULT);
    if (RO) begin : g_ro
      assign bytes_flat[b*8 +: 8] = 8'h00;
    end else begin : g_rw
      logic [OFS_W:0] rel;
      logic           hit;
      logic [7:0]     q;
      // rel wraps far above 4 when b lies below the start offset
      assign rel = (OFS_W+1)'(b) - {1'b0, off};
      assign hit = wr && (rel < {{(OFS_W-2){1'b0}}, clen});
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= INIT;
        else if (hit) q <= wdata[int'(rel[1:0])*8 +: 8];
      end
      assign bytes_flat[b*8 +: 8] = q;
    end
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < 4; i++) begin
      logic [OFS_W-1:0] a;
      a = off + OFS_W'(i);
      if (3'(i) < clen) rd_next[8*i +: 8] = bytes_flat[int'(a)*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_next;
    end
  end

  // R4: storage moves only under a write strobe
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(bytes_flat));

  // R10: read data returns one cycle after the strobe
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  // R3: lanes at or above a short length read zero
  p_tail_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && clen <= 3'd2) |=> (rdata[31:16] == 16'h0000));

endmodule

// File: rtl/pr_route_lookup.sv
module pr_route_lookup
  import pin_route_pkg::*;
#(
  parameter int REGION_BYTES = 64,
  parameter int ROUTE_BASE   = 8,
  parameter int FIRST_DEV    = 25,
  parameter int NUM_DEV      = 7,
  parameter int FIXED_DEV    = 30,
  parameter int PIN_SHIFT    = 4,
  localparam int FIXED_PIRQ0 = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [REGION_BYTES*8-1:0] bytes_flat,
  input  logic [4:0]                slot,
  input  logic [1:0]                pin,
  output pirq_t                     pirq
);

  logic [15:0] words [NUM_DEV];

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_word
    assign words[k] = bytes_flat[(ROUTE_BASE + 4*k)*8 +: 16];
  end

  always_comb begin
    pirq = slot_default_pirq(slot, pin);
    for (int k = 0; k < NUM_DEV; k++) begin
      if (int'(slot) == FIRST_DEV + k) begin
        if (FIRST_DEV + k == FIXED_DEV) pirq = 3'(FIXED_PIRQ0) + {1'b0, pin};
        else                            pirq = field_pirq(words[k], pin, PIN_SHIFT);
      end
    end
  end

  // R8: default slots stay on PIRQ E..H
  p_low_slot_eh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot) < FIRST_DEV) |-> pirq[2]);

  // R7: the hard-wired device stays on PIRQ E..H
  p_fixed_eh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot) == FIXED_DEV) |-> pirq[2]);

endmodule

// File: rtl/pci_pin_router.sv
module pci_pin_router
  import pin_route_pkg::*;
#(
  parameter int          AW            = 16,
  parameter int          REGION_BYTES  = 64,
  parameter int          ROUTE_BASE    = 8,
  parameter int          FIRST_DEV     = 25,
  parameter int          NUM_DEV       = 7,
  parameter int          FIXED_DEV     = 30,
  parameter int          PIN_SHIFT     = 4,
  parameter logic [15:0] ROUTE_DEFAULT = 16'h3210,
  parameter int          CTRL_OFS      = 48,
  parameter logic [31:0] CTRL_DEFAULT  = 32'h0000_0021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [AW-1:0] acc_addr,
  input  logic [2:0]    acc_len,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   acc_rdata,
  output logic          acc_rvalid,
  input  logic [4:0]    lk_slot,
  input  logic [1:0]    lk_pin,
  output logic [2:0]    lk_pirq,
  output logic          route_chg
);

  localparam int OFS_W   = $clog2(REGION_BYTES);
  localparam int FIXED_K = FIXED_DEV - FIRST_DEV;

  logic [OFS_W-1:0]          acc_off;
  logic [2:0]                acc_clen;
  logic [REGION_BYTES*8-1:0] bytes_flat;

  pr_access_clip #(.AW(AW), .REGION_BYTES(REGION_BYTES)) u_clip (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_wr | acc_rd),
    .addr(acc_addr), .len(acc_len), .off(acc_off), .clen(acc_clen)
  );

  pr_byte_store #(
    .REGION_BYTES(REGION_BYTES), .ROUTE_BASE(ROUTE_BASE), .NUM_DEV(NUM_DEV),
    .FIXED_K(FIXED_K), .ROUTE_DEFAULT(ROUTE_DEFAULT), .CTRL_OFS(CTRL_OFS),
    .CTRL_DEFAULT(CTRL_DEFAULT)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr(acc_wr), .rd(acc_rd), .off(acc_off),
    .clen(acc_clen), .wdata(acc_wdata), .rdata(acc_rdata), .rvalid(acc_rvalid),
    .bytes_flat(bytes_flat)
  );

  pr_route_lookup #(
    .REGION_BYTES(REGION_BYTES), .ROUTE_BASE(ROUTE_BASE), .FIRST_DEV(FIRST_DEV),
    .NUM_DEV(NUM_DEV), .FIXED_DEV(FIXED_DEV), .PIN_SHIFT(PIN_SHIFT)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n), .bytes_flat(bytes_flat),
    .slot(lk_slot), .pin(lk_pin), .pirq(lk_pirq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) route_chg <= 1'b0;
    else        route_chg <= acc_wr;
  end

  // R9: each write strobe is followed by one pulse
  p_chg_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> route_chg);

  // R9: no pulse without a write strobe
  p_chg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> !route_chg);

endmodule

// File: tb/tb_pci_pin_router.sv
module tb_pci_pin_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [2:0]  acc_len = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_rvalid;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;
  logic        route_chg;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0]  model [64];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  pci_pin_router dut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .lk_slot(lk_slot),
    .lk_pin(lk_pin), .lk_pirq(lk_pirq), .route_chg(route_chg)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ro_byte(int a);
    return a >= 28 && a < 32;
  endfunction

  function automatic int eff_len(int len);
    return (len > 4) ? 4 : len;
  endfunction

  task automatic do_write(int addr, int len, logic [31:0] d, string tag);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = 16'(addr); acc_len = 3'(len); acc_wdata = d;
    for (int i = 0; i < eff_len(len); i++) begin
      int a;
      a = (addr % 64) + i;
      if (a < 64 && !ro_byte(a)) model[a] = d[8*i +: 8];
    end
    @(negedge clk);
    acc_wr = 1'b0;
    check(route_chg == 1'b1, {tag, " R9 pulse"}, 32'(route_chg), 32'd1);
    @(negedge clk);
    check(route_chg == 1'b0, {tag, " R9 single"}, 32'(route_chg), 32'd0);
  endtask

  task automatic do_read(int addr, int len, string tag);
    logic [31:0] e;
    e = '0;
    for (int i = 0; i < eff_len(len); i++) begin
      int a;
      a = (addr % 64) + i;
      if (a < 64) e[8*i +: 8] = model[a];
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = 16'(addr); acc_len = 3'(len);
    @(negedge clk);
    acc_rd = 1'b0;
    check(route_chg == 1'b0, {tag, " R9 no pulse on read"}, 32'(route_chg), 32'd0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected read data", acc_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(acc_rdata == e, t, acc_rdata, e);
      end
    end
  end

  function automatic logic [2:0] exp_pirq(int slot, int pin);
    if (slot == 30) return 3'(pin + 4);
    if (slot >= 25) begin
      int base;
      logic [15:0] w;
      base = 8 + 4*(slot - 25);
      w = {model[base+1], model[base]};
      return 3'((w >> (pin*4)) & 16'h7);
    end
    return 3'(((slot + pin) % 4) + 4);
  endfunction

  task automatic check_lookup(int slot, int pin);
    logic [2:0] e;
    string tag;
    e = exp_pirq(slot, pin);
    tag = (slot == 30) ? "R7" : (slot >= 25) ? "R6" : "R8";
    lk_slot = 5'(slot); lk_pin = 2'(pin);
    #1;
    check(lk_pirq == e, $sformatf("%s lookup slot %0d pin %0d", tag, slot, pin),
          32'(lk_pirq), 32'(e));
  endtask

  task automatic sweep_lookup();
    @(negedge clk);
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) check_lookup(s, p);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    for (int k = 0; k < 7; k++) begin
      if (k != 5) begin
        model[8 + 4*k]     = 8'h10;
        model[8 + 4*k + 1] = 8'h32;
      end
    end
    model[48] = 8'h21;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(route_chg == 1'b0, "R1 pulse low after reset", 32'(route_chg), 32'd0);
    check(acc_rvalid == 1'b0, "R1 rvalid low after reset", 32'(acc_rvalid), 32'd0);

    // R1: reset image, word by word
    for (int a = 0; a < 64; a += 4) do_read(a, 4, $sformatf("R1 reset word @%0d", a));
    sweep_lookup();

    // R6 / R9: program device 25 and device 31
    do_write(8, 2, 32'h0000_7654, "R6 dev25");
    do_write(32, 4, 32'hDEAD_0A5C, "R6 dev31");
    sweep_lookup();
    do_read(8, 4, "R4 dev25 readback");

    // R2: aliased address reaches device 27
    do_write(16 + 64*3, 2, 32'h0000_1357, "R2 alias write");
    do_read(16, 2, "R2 alias readback");
    do_read(16 + 128, 4, "R2 alias read high");
    check_lookup(27, 1);

    // R3: clip at top edge
    do_write(62, 4, 32'hAABB_CCDD, "R3 edge write");
    do_read(62, 4, "R3 edge read");
    do_read(63, 3, "R3 last byte read");
    do_read(60, 4, "R3 neighbour intact");

    // R5 / R7: hard-wired device ignores writes
    do_write(28, 4, 32'hFFFF_FFFF, "R5 fixed write");
    do_read(28, 4, "R5 fixed reads zero");
    do_write(26, 4, 32'h7777_6666, "R5 straddle write");
    do_read(26, 4, "R5 straddle read");
    for (int p = 0; p < 4; p++) check_lookup(30, p);
    check_lookup(29, 3);

    // R4: partial lengths, long length, zero length
    do_write(40, 1, 32'h1122_3344, "R4 len1");
    do_write(41, 3, 32'h5566_7788, "R4 len3");
    do_read(40, 4, "R4 partial read");
    do_write(4, 7, 32'h0102_0304, "R4 len7 acts as 4");
    do_read(4, 7, "R4 len7 read");
    do_write(12, 0, 32'hFFFF_FFFF, "R4 len0 write");
    do_read(12, 4, "R4 len0 no change");
    do_read(12, 0, "R3 len0 read zero");
    sweep_lookup();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads returned", 32'(exp_q.size()), 32'd0);
    done = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      report();
    end
  end

endmodule